// File: doc/BRIEF.md
# Random Allocation Tag Generator

This block picks a 4-bit allocation tag for a pointer-tagging memory safety scheme and places it into the upper bits of a pointer. A 16-bit seed and a 4-bit start tag live in a state word held outside the block. On a random request the seed is advanced by a linear feedback shift register for four steps. The four feedback bits form an offset. A walker then moves through the 16 tag values from the start tag, skipping every value whose bit is set in the exclusion mask, and lands on the result. The updated state is returned for write-back.

A second request kind adjusts the tag already in a pointer. It starts from the pointer's own tag, uses an offset given with the request, and skips only the values excluded by the control mask. The seed is not touched. Requests use a valid/ready handshake. The walk takes several cycles, and a one-cycle done pulse marks the result.

Top module: `tag_rand_gen`

## Requirements
- R1: One seed step computes the XOR of seed bits 5, 3, 2 and 0, shifts the seed right by one, and places that bit at bit 15. Seed 0x0001 with start tag 0 and no exclusions gives tag 1 and new seed 0x1000.
- R2: A random request performs four seed steps, and the feedback bit of step i becomes bit i of the 4-bit offset.
- R3: When the effective exclusion mask is 0xFFFF, the result tag is 0 for either request kind.
- R4: With offset 0, the result is the first non-excluded value reached by counting up modulo 16 from the start tag, including the start tag itself.
- R5: With a non-zero offset, the walker advances offset times. Each advance moves at least one place modulo 16 and keeps moving while the current value is excluded.
- R6: For a random request, the effective exclusion mask is ctrl_excl OR req_excl (bit n excludes tag n).
- R7: On done for a random request, st_we is 1 and st_out holds the tag in bits 3:0, zero in bits 7:4 and the new seed in bits 23:8. The start tag is read from st_in bits 3:0 and the seed from st_in bits 23:8.
- R8: An add request (req_op=1) takes pointer bits 59:56 as the start tag and req_ofs as the offset, uses only ctrl_excl, ignores req_excl, and leaves st_we at 0.
- R9: req_ready is 1 when the block is idle and falls for the cycle after a request is accepted. It stays low until done. done is a single-cycle pulse.
- R10: res_ptr equals the request pointer with bits 59:56 replaced by the result tag.
- R11: A zero seed stays zero and gives offset 0.
- R12: After reset, req_ready is 1 and done and st_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_op | input | 1 | 0 random tag, 1 add offset to pointer tag |
| req_ptr | input | 64 | Pointer to be tagged |
| req_excl | input | 16 | Per-request exclusion mask (random only) |
| req_ofs | input | 4 | Tag offset for add requests |
| ctrl_excl | input | 16 | Control register exclusion mask |
| st_in | input | 24 | Current state: seed 23:8, start tag 3:0 |
| done | output | 1 | Result valid pulse |
| res_tag | output | 4 | Chosen tag |
| res_ptr | output | 64 | Pointer carrying the chosen tag |
| st_out | output | 24 | Updated state for write-back |
| st_we | output | 1 | Write-back strobe for st_out |

## Verification
On every cycle the assertions check the handshake: ready drops after an accept, done lasts one cycle, and write-back happens only for random requests. They also check two properties of every result: it never lands on an excluded value unless all values are excluded, and a full mask always gives tag 0. Whether a tag is the correct one among several legal values needs the bench. That covers the exact LFSR sequence, the offset-driven walk length, wrap-around past 15, and the use of the pointer's own tag as the start. The bench computes each of these from its own model, over chained random requests and crafted exclusion masks.

// File: rtl/tagsel_pkg.sv
package tagsel_pkg;
   localparam int TAG_W   = 4;
   localparam int NTAGS   = 1 << TAG_W;
   localparam logic [15:0] TAP_MASK16 = 16'h002D;   // seed bits 5,3,2,0
   localparam logic OP_RAND = 1'b0;
   localparam logic OP_ADD  = 1'b1;
endpackage

// File: rtl/tagsel_seed_adv.sv
module tagsel_seed_adv
   import tagsel_pkg::*;
#(
   parameter int SEED_W = 16,
   parameter int STEPS  = 4,
   parameter logic [SEED_W-1:0] TAPS = SEED_W'(TAP_MASK16)
) (
   input  logic [SEED_W-1:0] seed_i,
   output logic [SEED_W-1:0] seed_o,
   output logic [TAG_W-1:0]  ofs_o
);
   logic [SEED_W-1:0] chain [0:STEPS];
   assign chain[0] = seed_i;

   for (genvar g = 0; g < STEPS; g++) begin : g_step
      logic fb;
      assign fb         = ^(chain[g] & TAPS);
      assign chain[g+1] = {fb, chain[g][SEED_W-1:1]};
      assign ofs_o[g]   = fb;
   end

   if (STEPS < TAG_W) begin : g_pad
      assign ofs_o[TAG_W-1:STEPS] = '0;
   end

   assign seed_o = chain[STEPS];
endmodule

// File: rtl/tagsel_walker.sv
module tagsel_walker
   import tagsel_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TAG_W-1:0] start_tag,
   input  logic [TAG_W-1:0] ofs,
   input  logic [NTAGS-1:0] load_mask,
   input  logic [NTAGS-1:0] walk_mask,
   output logic             idle,
   output logic             fin,
   output logic [TAG_W-1:0] tag
);
   typedef enum logic [1:0] {W_IDLE, W_WALK, W_FIN} wst_e;
   wst_e             st;
   logic [TAG_W-1:0] cur, rem, cur_inc;

   assign cur_inc = cur + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= W_IDLE;
         cur <= '0;
         rem <= '0;
      end else begin
         case (st)
            W_IDLE: if (load) begin
               rem <= ofs;
               if (&load_mask) begin
                  cur <= '0;
                  st  <= W_FIN;
               end else begin
                  cur <= start_tag;
                  st  <= W_WALK;
               end
            end
            W_WALK: begin
               if (rem == '0) begin
                  if (!walk_mask[cur]) st  <= W_FIN;
                  else                 cur <= cur_inc;
               end else begin
                  cur <= cur_inc;
                  if (!walk_mask[cur_inc]) rem <= rem - 1'b1;
               end
            end
            default: st <= W_IDLE;
         endcase
      end
   end

   assign idle = (st == W_IDLE);
   assign fin  = (st == W_FIN);
   assign tag  = cur;
endmodule

// File: rtl/tag_rand_gen.sv
module tag_rand_gen
   import tagsel_pkg::*;
#(
   parameter int PTR_W   = 64,
   parameter int TAG_LSB = 56,
   parameter int SEED_W  = 16,
   parameter int STEPS   = 4,
   localparam int SEED_LSB = 8,
   localparam int ST_W     = SEED_LSB + SEED_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_op,
   input  logic [PTR_W-1:0] req_ptr,
   input  logic [NTAGS-1:0] req_excl,
   input  logic [TAG_W-1:0] req_ofs,
   input  logic [NTAGS-1:0] ctrl_excl,
   input  logic [ST_W-1:0]  st_in,
   output logic             done,
   output logic [TAG_W-1:0] res_tag,
   output logic [PTR_W-1:0] res_ptr,
   output logic [ST_W-1:0]  st_out,
   output logic             st_we
);
   if (TAG_LSB + TAG_W > PTR_W) begin : g_bad_tag_pos
      $error("tag field does not fit in the pointer");
   end
   if (STEPS > TAG_W || STEPS < 1) begin : g_bad_steps
      $error("seed steps must be between 1 and the tag width");
   end
   if (SEED_W < 6) begin : g_bad_seed
      $error("seed too narrow for the feedback taps");
   end

   logic              accept, w_idle, w_fin;
   logic [SEED_W-1:0] seed_cur, seed_nxt;
   logic [TAG_W-1:0]  rnd_ofs, sel_start, sel_ofs, w_tag;
   logic [NTAGS-1:0]  sel_mask;
   logic [PTR_W-1:0]  ptr_q;
   logic              op_q;
   logic [SEED_W-1:0] seed_q;
   logic [NTAGS-1:0]  mask_q;
   logic              unused_st;

   assign seed_cur  = st_in[ST_W-1:SEED_LSB];
   assign unused_st = ^st_in[SEED_LSB-1:TAG_W];

   tagsel_seed_adv #(.SEED_W(SEED_W), .STEPS(STEPS)) u_seed (
      .seed_i(seed_cur), .seed_o(seed_nxt), .ofs_o(rnd_ofs)
   );

   always_comb begin
      if (req_op == OP_ADD) begin
         sel_start = req_ptr[TAG_LSB +: TAG_W];
         sel_ofs   = req_ofs;
         sel_mask  = ctrl_excl;
      end else begin
         sel_start = st_in[TAG_W-1:0];
         sel_ofs   = rnd_ofs;
         sel_mask  = ctrl_excl | req_excl;
      end
   end

   assign req_ready = w_idle;
   assign accept    = req_valid & req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         op_q   <= OP_RAND;
         seed_q <= '0;
         mask_q <= '0;
      end else if (accept) begin
         ptr_q  <= req_ptr;
         op_q   <= req_op;
         seed_q <= seed_nxt;
         mask_q <= sel_mask;
      end
   end

   tagsel_walker u_walk (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .start_tag(sel_start), .ofs(sel_ofs),
      .load_mask(sel_mask), .walk_mask(mask_q),
      .idle(w_idle), .fin(w_fin), .tag(w_tag)
   );

   always_comb begin
      res_ptr = ptr_q;
      res_ptr[TAG_LSB +: TAG_W] = w_tag;
   end

   assign done    = w_fin;
   assign res_tag = w_tag;
   assign st_out  = {seed_q, {(SEED_LSB-TAG_W){1'b0}}, w_tag};
   assign st_we   = w_fin & (op_q == OP_RAND);
endmodule

// File: rtl/tagsel_chk.sv
module tagsel_chk
   import tagsel_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             done,
   input logic             st_we,
   input logic             op_q,
   input logic [TAG_W-1:0] res_tag,
   input logic [NTAGS-1:0] mask_q,
   input logic [TAG_W-1:0] st_tag
);
   // R9
   accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);
   // R9
   done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_ready);
   // R3
   full_mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && (&mask_q) |-> res_tag == '0);
   // R4
   result_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !(&mask_q) |-> !mask_q[res_tag]);
   // R7
   writeback_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_we |-> done && st_tag == res_tag);
   // R8
   add_no_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && op_q == OP_ADD |-> !st_we);
endmodule

bind tag_rand_gen tagsel_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .done(done), .st_we(st_we), .op_q(op_q), .res_tag(res_tag),
   .mask_q(mask_q), .st_tag(st_out[3:0])
);

// File: tb/tb_tag_rand_gen.sv
module tb_tag_rand_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_op = 1'b0;
   logic [63:0] req_ptr = '0;
   logic [15:0] req_excl = '0;
   logic [3:0]  req_ofs = '0;
   logic [15:0] ctrl_excl = '0;
   logic [23:0] st_in = '0;
   logic        done;
   logic [3:0]  res_tag;
   logic [63:0] res_ptr;
   logic [23:0] st_out;
   logic        st_we;

   int checks = 0;
   int errors = 0;
   logic [3:0]  g_tag;
   logic [63:0] g_ptr;
   logic [23:0] g_st;
   logic        g_we;

   always #5 clk = ~clk;

   tag_rand_gen dut (.*);

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [19:0] mdl_seed(input logic [15:0] s);
      logic [15:0] x = s;
      logic [3:0]  o = '0;
      for (int i = 0; i < 4; i++) begin
         logic b = x[5] ^ x[3] ^ x[2] ^ x[0];
         x = {b, x[15:1]};
         o[i] = b;
      end
      return {x, o};
   endfunction

   function automatic logic [3:0] mdl_pick(input logic [3:0] s, input logic [3:0] o,
                                           input logic [15:0] m);
      logic [3:0] t = s;
      if (m == 16'hFFFF) return 4'd0;
      if (o == 0) begin
         for (int k = 0; k < 16; k++) begin
            if (!m[t]) break;
            t = t + 1'b1;
         end
      end else begin
         for (int j = 0; j < 16; j++) begin
            if (j >= o) break;
            t = t + 1'b1;
            for (int k = 0; k < 16; k++) begin
               if (!m[t]) break;
               t = t + 1'b1;
            end
         end
      end
      return t;
   endfunction

   task automatic do_req(input logic op, input logic [63:0] ptr, input logic [15:0] ex,
                         input logic [3:0] ofs);
      int n = 0;
      while (!req_ready && n < 50) begin @(negedge clk); n++; end
      req_op = op; req_ptr = ptr; req_excl = ex; req_ofs = ofs; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R9 ready low after accept", req_ready, 1'b0);
      n = 0;
      while (!done && n < 400) begin @(negedge clk); n++; end
      check("R9 done reached", done, 1'b1);
      g_tag = res_tag; g_ptr = res_ptr; g_st = st_out; g_we = st_we;
      @(negedge clk);
      check("R9 done single pulse", done, 1'b0);
   endtask

   task automatic t_reset();
      check("R12 ready after reset", req_ready, 1'b1);
      check("R12 done after reset", done, 1'b0);
      check("R12 st_we after reset", st_we, 1'b0);
   endtask

   task automatic t_known_seed();
      ctrl_excl = 16'h0; st_in = 24'h000100;
      do_req(1'b0, 64'h0000_1234_5678_9ABC, 16'h0, 4'h0);
      check("R1 R2 tag for seed 1", g_tag, 4'h1);
      check("R7 state write-back", g_st, 24'h100001);
      check("R7 st_we on random", g_we, 1'b1);
   endtask

   task automatic t_full_mask();
      ctrl_excl = 16'hFF00; st_in = 24'hACE105;
      do_req(1'b0, 64'h0F00_0000_0000_0040, 16'h00FF, 4'h0);
      check("R3 R6 full mask random", g_tag, 4'h0);
      check("R10 ptr tag field", g_ptr, 64'h0000_0000_0000_0040);
      ctrl_excl = 16'hFFFF;
      do_req(1'b1, 64'h0900_0000_0000_0000, 16'h0, 4'h3);
      check("R3 full mask add", g_tag, 4'h0);
   endtask

   task automatic t_add_zero();
      ctrl_excl = 16'h0060;
      do_req(1'b1, 64'h0500_0000_DEAD_0000, 16'hFFFF, 4'h0);
      check("R4 R8 first allowed from 5", g_tag, 4'h7);
      check("R8 no write-back on add", g_we, 1'b0);
      check("R10 pointer kept", g_ptr, 64'h0700_0000_DEAD_0000);
      ctrl_excl = 16'h8000;
      do_req(1'b1, 64'h0F00_0000_0000_0000, 16'h0, 4'h0);
      check("R4 wrap past 15", g_tag, 4'h0);
      ctrl_excl = 16'h0000;
      do_req(1'b1, 64'h0B00_0000_0000_0000, 16'h0, 4'h0);
      check("R4 start tag allowed", g_tag, 4'hB);
   endtask

   task automatic t_add_walk();
      ctrl_excl = 16'h8002;
      do_req(1'b1, 64'h0E00_0000_0000_0010, 16'h0, 4'h3);
      check("R5 skip 15 and 1", g_tag, 4'h3);
      ctrl_excl = 16'h0000;
      do_req(1'b1, 64'h0200_0000_0000_0000, 16'hFFFE, 4'h1);
      check("R8 request mask ignored", g_tag, 4'h3);
      ctrl_excl = 16'h7FFF;
      do_req(1'b1, 64'h0F00_0000_0000_0000, 16'h0, 4'hF);
      check("R5 single allowed value", g_tag, 4'hF);
   endtask

   task automatic t_zero_seed();
      ctrl_excl = 16'h0; st_in = 24'h000007;
      do_req(1'b0, 64'h0, 16'h0, 4'h0);
      check("R11 zero seed tag", g_tag, 4'h7);
      check("R11 zero seed state", g_st, 24'h000007);
   endtask

   task automatic t_chain();
      logic [23:0] st = 24'hBEEF03;
      ctrl_excl = 16'h0421;
      for (int i = 0; i < 12; i++) begin
         logic [19:0] so;
         logic [15:0] ex = 16'h1 << (i % 16);
         logic [3:0]  tg;
         so = mdl_seed(st[23:8]);
         tg = mdl_pick(st[3:0], so[3:0], ctrl_excl | ex);
         st_in = st;
         do_req(1'b0, 64'h00AA_0000_0000_1000, ex, 4'h0);
         check("R5 R6 chained tag", g_tag, tg);
         check("R7 chained state", g_st, {so[19:4], 4'h0, tg});
         check("R10 chained ptr", g_ptr, {8'h0, 4'h0, 52'h0}
               | 64'h00AA_0000_0000_1000 | (64'(tg) << 56));
         st = g_st;
      end
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_known_seed();
            t_full_mask();
            t_add_zero();
            t_add_walk();
            t_zero_seed();
            t_chain();
         end
         begin
            repeat (20000) @(negedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule